// File: doc/BRIEF.md
# Integer Arithmetic Unit with Condition Flags

This block is a width-parameterised integer adder/subtractor with a registered four-bit condition field. It can add, add with carry-in, subtract, subtract with borrow, and subtract in reverse operand order, with or without borrow. Each operation uses two register operands. Every subtraction is formed as one operand plus the inverted other operand plus a carry-in. As a result, a stored carry of 1 means that no borrow took place.

The result is combinational. It depends on the operands, the operation code and the carry bit held in the flag register. The flag register captures the negative, zero, carry and overflow conditions on the clock edge, and only when the caller asserts the set-flags input for that operation. This allows a sequence of operations to run without disturbing flags that a later step depends on. Multi-word arithmetic is built by chaining a carry-using operation after a flag-setting one.

The width is 32 bits by default. It can be reduced to 4 or 8 bits so that exhaustive and corner-case checking stays short.

Top module: `arith_flag_unit`

## Requirements
- R1: Operation code 0 gives a+b, and code 1 gives a+b+C, where C is the stored carry flag. Both wrap modulo 2^W.
- R2: Code 2 gives a-b, computed as a+~b+1. Code 3 gives a-b+C-1, computed as a+~b+C.
- R3: Code 4 gives b-a, computed as b+~a+1. Code 5 gives b-a+C-1, computed as b+~a+C.
- R4: When flags are written, flags[3] (negative) equals result bit W-1, and flags[2] (zero) is 1 exactly when every result bit is 0.
- R5: When flags are written, flags[1] (carry) is the carry out of bit W-1 of the internal addition. For subtractions, 1 therefore means no borrow.
- R6: When flags are written, flags[0] (overflow) is 1 exactly when the signed result lies outside -2^(W-1)..2^(W-1)-1.
- R7: The flags change on a clock edge only when set_flags is 1 in that cycle. Otherwise they keep their value, while result is still produced.
- R8: Codes 1, 3 and 5 use the carry held in the flag register before the current edge, never the carry being computed.
- R9: A synchronous reset (rst high at a clock edge) clears all four flags to 0.
- R10: Codes 6 and 7 produce a zero result and leave the flags unchanged even when set_flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation code (0..5 valid, 6 and 7 unused) |
| set_flags | input | 1 | Write the condition flags at the next edge |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| result | output | W | Combinational arithmetic result |
| flags | output | 4 | Stored flags {negative, zero, carry, overflow} |

## Verification
The unit is run at 8 bits with directed pairs chosen to isolate each flag. These include a signed wrap past the positive limit and one past the negative limit, sums that carry without overflowing, subtractions with and without borrow, and equal operands that give zero. The pairs tell apart the carry, overflow and zero conditions, which a single ordinary operand pair would let coincide. Chains of carry-using operations, issued after both carry states, separate use of the stored carry from use of a fresh one. Random codes, operands and set-flags values then mix writes with hold cycles and unused codes, so that a flag updating when it should hold shows up.

// File: rtl/arith_pkg.sv
package arith_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDC  = 3'd1,
        OP_SUB   = 3'd2,
        OP_SUBC  = 3'd3,
        OP_RSUB  = 3'd4,
        OP_RSUBC = 3'd5
    } op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/arith_opsel.sv
module arith_opsel
    import arith_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         carry_q,
    output logic [W-1:0] add_x,
    output logic [W-1:0] add_y,
    output logic         add_cin,
    output logic         op_valid
);

    op_e op;
    assign op = op_e'(op_sel);

    always_comb begin
        add_x    = '0;
        add_y    = '0;
        add_cin  = 1'b0;
        op_valid = 1'b1;
        unique case (op)
            OP_ADD:   begin add_x = opnd_a; add_y = opnd_b;  add_cin = 1'b0;    end
            OP_ADDC:  begin add_x = opnd_a; add_y = opnd_b;  add_cin = carry_q; end
            OP_SUB:   begin add_x = opnd_a; add_y = ~opnd_b; add_cin = 1'b1;    end
            OP_SUBC:  begin add_x = opnd_a; add_y = ~opnd_b; add_cin = carry_q; end
            OP_RSUB:  begin add_x = opnd_b; add_y = ~opnd_a; add_cin = 1'b1;    end
            OP_RSUBC: begin add_x = opnd_b; add_y = ~opnd_a; add_cin = carry_q; end
            default:  op_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/arith_adder.sv
module arith_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    input  logic         add_cin,
    output logic [W-1:0] sum,
    output logic         carry_into_msb,
    output logic         carry_out
);

    logic [W-1:0] low_part;
    logic [1:0]   top_part;

    // Lower W-1 bits plus a spare bit that holds the carry into the MSB
    assign low_part = {1'b0, add_x[W-2:0]} + {1'b0, add_y[W-2:0]}
                    + {{(W-1){1'b0}}, add_cin};
    assign top_part = {1'b0, add_x[W-1]} + {1'b0, add_y[W-1]}
                    + {1'b0, low_part[W-1]};

    assign sum            = {top_part[0], low_part[W-2:0]};
    assign carry_into_msb = low_part[W-1];
    assign carry_out      = top_part[1];

endmodule

// File: rtl/arith_flagreg.sv
module arith_flagreg
    import arith_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  flags_t flags_d,
    output flags_t flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import arith_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_sel,
    input  logic         set_flags,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic [3:0]   flags
);

    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_cin;
    logic         op_valid;
    logic         c_msb_in;
    logic         c_out;
    flags_t       flags_d;
    flags_t       flags_q;

    arith_opsel #(.W(W)) u_opsel (
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .carry_q  (flags_q.carry),
        .add_x    (add_x),
        .add_y    (add_y),
        .add_cin  (add_cin),
        .op_valid (op_valid)
    );

    arith_adder #(.W(W)) u_adder (
        .add_x          (add_x),
        .add_y          (add_y),
        .add_cin        (add_cin),
        .sum            (result),
        .carry_into_msb (c_msb_in),
        .carry_out      (c_out)
    );

    always_comb begin
        flags_d.neg   = result[W-1];
        flags_d.zero  = ~|result;
        flags_d.carry = c_out;
        flags_d.ovf   = c_msb_in ^ c_out;
    end

    arith_flagreg u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (set_flags & op_valid),
        .flags_d (flags_d),
        .flags_q (flags_q)
    );

    assign flags = flags_q;

endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_sel,
    input logic         set_flags,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic [3:0]   flags
);

    logic wr;
    assign wr = set_flags && (op_sel < 3'd6);

    // R9: synchronous reset empties the flags
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (flags == 4'b0000));

    // R7: no write request, no flag change
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(flags));

    // R10: unused codes leave flags alone and output zero
    a_r10_unused_hold: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 3'd6) |=> $stable(flags));
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 3'd6) |-> (result == '0));

    // R4: negative and zero follow the result that was written
    a_r4_neg: assert property (@(posedge clk) disable iff (rst)
        wr |=> (flags[3] == $past(result[W-1])));
    a_r4_zero: assert property (@(posedge clk) disable iff (rst)
        wr |=> (flags[2] == ($past(result) == '0)));

    // R5: plain add carries exactly when the wrapped sum falls below an operand
    a_r5_add_carry: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_sel == 3'd0) |=> (flags[1] == ($past(result) < $past(opnd_a))));

    // R6: plain add overflows when same-sign operands give a different-sign result
    a_r6_add_ovf: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_sel == 3'd0) |=>
        (flags[0] == $past((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1]))));

endmodule

bind arith_flag_unit arith_flag_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_sel    (op_sel),
    .set_flags (set_flags),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .flags     (flags)
);

// File: tb/sim_arith_flag_unit.sv
`timescale 1ns/1ps
module sim_arith_flag_unit;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [2:0]   op_sel;
    logic         set_flags;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [W-1:0] result;
    logic [3:0]   flags;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  finished = 1'b0;
    logic [3:0] exp_flags;

    always #2.5 clk = ~clk;

    arith_flag_unit #(.W(W)) u0 (
        .clk(clk), .rst(rst), .op_sel(op_sel), .set_flags(set_flags),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .flags(flags)
    );

    // Reference: returns {result, neg, zero, carry, ovf}
    function automatic logic [W+3:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic c);
        logic [W-1:0] x, y;
        logic         ci;
        logic [W:0]   s;
        logic         v;
        case (op)
            3'd0: begin x = a; y = b;  ci = 1'b0; end
            3'd1: begin x = a; y = b;  ci = c;    end
            3'd2: begin x = a; y = ~b; ci = 1'b1; end
            3'd3: begin x = a; y = ~b; ci = c;    end
            3'd4: begin x = b; y = ~a; ci = 1'b1; end
            3'd5: begin x = b; y = ~a; ci = c;    end
            default: return '0;
        endcase
        s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
        return {s[W-1:0], s[W-1], (s[W-1:0] == '0), s[W], v};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic do_op(input logic [2:0] op, input logic sf,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W+3:0] m;
        string rtag, ftag;
        op_sel = op; set_flags = sf; opnd_a = a; opnd_b = b;
        #1;
        m = model(op, a, b, exp_flags[1]);
        case (op)
            3'd0, 3'd1: rtag = "R1 R8 add result";
            3'd2, 3'd3: rtag = "R2 R8 sub result";
            3'd4, 3'd5: rtag = "R3 R8 reverse sub result";
            default:    rtag = "R10 unused code result";
        endcase
        check(rtag, 32'(result), 32'(m[W+3:4]));
        if (sf && op < 3'd6) begin
            exp_flags = m[3:0];
            ftag = "R4 R5 R6 flags";
        end else if (op >= 3'd6) begin
            ftag = "R10 flags kept";
        end else begin
            ftag = "R7 flags kept";
        end
        @(negedge clk);
        check(ftag, 32'(flags), 32'(exp_flags));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_flags = 4'b0000;
        check("R9 flags after reset", 32'(flags), 32'h0);
    endtask

    initial begin
        rst = 1'b1; op_sel = '0; set_flags = 1'b0; opnd_a = '0; opnd_b = '0;
        exp_flags = '0;
        void'($urandom(32'd5150));
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // Directed corner cases
        do_op(3'd0, 1'b1, 8'hCA, 8'h17);   // R1 no carry, negative
        do_op(3'd0, 1'b1, 8'hF0, 8'hF8);   // R5 carry, no overflow
        do_op(3'd2, 1'b1, 8'h6F, 8'h75);   // R2 borrow -> C=0
        do_op(3'd2, 1'b1, 8'hC5, 8'hD6);   // R2
        do_op(3'd0, 1'b1, 8'h7F, 8'h01);   // R6 positive overflow
        do_op(3'd2, 1'b1, 8'h80, 8'h01);   // R6 negative overflow
        do_op(3'd2, 1'b1, 8'h33, 8'h33);   // R4 zero, R5 C=1
        do_op(3'd4, 1'b1, 8'h05, 8'h1A);   // R3 reverse subtract
        do_op(3'd1, 1'b0, 8'hFF, 8'h00);   // R8 uses stored C=1, R7 no write
        do_op(3'd3, 1'b1, 8'h10, 8'h10);   // R8 SBC with C=1 -> zero
        do_op(3'd0, 1'b1, 8'h00, 8'h00);   // clear carry
        do_op(3'd5, 1'b1, 8'h01, 8'h01);   // R8 RSC with C=0 -> -1
        do_op(3'd1, 1'b1, 8'h00, 8'h00);   // R8 ADC with C=0
        do_op(3'd6, 1'b1, 8'hAA, 8'h55);   // R10
        do_op(3'd7, 1'b1, 8'hFF, 8'hFF);   // R10

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            do_op(3'($urandom_range(7)), 1'($urandom_range(1)),
                  W'($urandom), W'($urandom));
            if (i == 1500) do_reset();
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule